// File: doc/BRIEF.md
# Chained Serial Configuration Register Bank

This block is the configuration slave of a front-end readout chip. A host sends fixed-length command frames over three wires (serial clock, serial data, load strobe). Inside the chip an 18-bit frame register sits in the data path. Bits enter at its least significant end, and its most significant bit drives the serial output, which is wired to the serial input of the next chip. A string of chips therefore looks to the host like one long shift register, 18 bits per chip. The host shifts one frame into every chip and then raises the shared load strobe. Each chip then acts on the frame it holds.

A frame either writes one of 98 ten-bit registers or reads one of them back. A read places the register value in the data field of the frame register, and the next round of shifting carries it out towards the host. Every register is also driven in parallel onto a flat output bus. That bus feeds threshold, bias, shaping, sampling-rate, calibration and power-cycling controls elsewhere on the chip. The three serial inputs are asynchronous. They are resynchronised to the chip clock, and the block acts on their rising edges.

Top module: `cfg_chain_slave`

## Requirements
- R1: While reset is asserted and after it, every register holds 10'h200, so `cfg_regs_o` is that value repeated 98 times. The frame register is zero and `sdo_o` is 0.
- R2: A frame is 18 bits, sent most significant bit first. Bit 17 is the operation (1 = write, 0 = read), bits 16:10 are the register address, and bits 9:0 are the data.
- R3: On each rising edge of `sclk_i`, the value of `sdi_i` enters bit 0 and the frame moves up one place. `sdo_o` always shows bit 17, so a bit reappears at `sdo_o` after 18 further rising edges.
- R4: On a rising edge of `load_i` with a write frame held and address below 98, the addressed register takes the data field. Register n appears on `cfg_regs_o[10n+9:10n]` within 4 clock cycles.
- R5: On a rising edge of `load_i` with a read frame held and address below 98, the data field of the frame register is replaced by the addressed register. Bits 17:10 are kept, and the next 18 shifts return the whole frame on `sdo_o`.
- R6: A write frame whose address is 98 or higher changes no register.
- R7: A read frame whose address is 98 or higher loads zero into the data field.
- R8: Shifting without a rising edge of `load_i` changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip clock that samples the serial inputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdi_i | input | 1 | Serial data from the host or the previous chip |
| load_i | input | 1 | Load strobe; its rising edge executes the held frame |
| sdo_o | output | 1 | Serial data to the next chip (frame bit 17) |
| cfg_regs_o | output | 980 | All registers, register n at bits 10n+9:10n |

## Verification
A wrong bit in the frame register shows up at `sdo_o` during the next shift round, at most 18 serial clocks later. The scoreboard compares every shifted-out bit against a model of the frame, so such an error appears there. A wrong register value shows up on `cfg_regs_o` within 4 clock cycles of the load edge. It also shows up one shift round later in the data field of a read-back. Corrupted decoding of out-of-range addresses shows up as a changed bus after the load, or as a non-zero read field.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
  parameter int unsigned CFG_NUM_REGS = 98;
  parameter int unsigned CFG_DATA_W   = 10;
  parameter logic [CFG_DATA_W-1:0] CFG_RST_VAL = 10'h200;
  localparam int unsigned CFG_ADDR_W  = $clog2(CFG_NUM_REGS);
  localparam int unsigned CFG_FRAME_W = 1 + CFG_ADDR_W + CFG_DATA_W;

  typedef struct packed {
    logic                  wr;
    logic [CFG_ADDR_W-1:0] addr;
    logic [CFG_DATA_W-1:0] data;
  } cfg_frame_t;
endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g] <= 1'b0;
        s2_q[g] <= 1'b0;
        s3_q[g] <= 1'b0;
      end else begin
        s1_q[g] <= async_i[g];
        s2_q[g] <= s1_q[g];
        s3_q[g] <= s2_q[g];
      end
    end
    assign rise_o[g] = s2_q[g] & ~s3_q[g];
  end

  assign level_o = s2_q;

  // a rise lasts exactly one cycle
  for (genvar g = 0; g < W; g++) begin : g_chk
    p_rise_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/cfg_frame_shifter.sv
module cfg_frame_shifter
  import cfg_chain_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  shift_i,
  input  logic                  sdi_i,
  input  logic                  rd_load_i,
  input  logic [CFG_DATA_W-1:0] rd_data_i,
  output cfg_frame_t            frame_o
);
  logic [CFG_FRAME_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
    end else if (rd_load_i) begin
      frame_q[CFG_DATA_W-1:0] <= rd_data_i;
    end else if (shift_i) begin
      frame_q <= {frame_q[CFG_FRAME_W-2:0], sdi_i};
    end
  end

  assign frame_o = cfg_frame_t'(frame_q);

  p_shift_in_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && !rd_load_i |=>
      frame_q == {$past(frame_q[CFG_FRAME_W-2:0]), $past(sdi_i)});

  p_read_keeps_header_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load_i |=> frame_q[CFG_FRAME_W-1:CFG_DATA_W] == $past(frame_q[CFG_FRAME_W-1:CFG_DATA_W]));

  p_read_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load_i |=> frame_q[CFG_DATA_W-1:0] == $past(rd_data_i));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_chain_pkg::*;
(
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [CFG_ADDR_W-1:0]              addr_i,
  input  logic [CFG_DATA_W-1:0]              wr_data_i,
  output logic [CFG_DATA_W-1:0]              rd_data_o,
  output logic [CFG_NUM_REGS*CFG_DATA_W-1:0] regs_o
);
  logic [CFG_DATA_W-1:0] bank_q [CFG_NUM_REGS];
  logic                  addr_ok;

  assign addr_ok = {1'b0, addr_i} < (CFG_ADDR_W+1)'(CFG_NUM_REGS);

  for (genvar g = 0; g < CFG_NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         bank_q[g] <= CFG_RST_VAL;
      else if (wr_en_i && addr_i == CFG_ADDR_W'(g))        bank_q[g] <= wr_data_i;
    end
    assign regs_o[g*CFG_DATA_W +: CFG_DATA_W] = bank_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_ok) rd_data_o = bank_q[addr_i];
  end

  p_write_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_ok |=> bank_q[$past(addr_i)] == $past(wr_data_i));

  p_oob_write_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !addr_ok |=> $stable(regs_o));

  p_no_write_no_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o));

  p_oob_read_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_ok |-> rd_data_o == '0);
endmodule

// File: rtl/cfg_chain_slave.sv
module cfg_chain_slave
  import cfg_chain_pkg::*;
(
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               sclk_i,
  input  logic                               sdi_i,
  input  logic                               load_i,
  output logic                               sdo_o,
  output logic [CFG_NUM_REGS*CFG_DATA_W-1:0] cfg_regs_o
);
  localparam int unsigned IdxSclk = 0;
  localparam int unsigned IdxSdi  = 1;
  localparam int unsigned IdxLoad = 2;

  logic [2:0]            in_level, in_rise;
  logic                  load_rise, shift_en, wr_en, rd_load;
  logic [CFG_DATA_W-1:0] rd_data;
  cfg_frame_t            frame;

  cfg_sync_edge #(.W(3)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({load_i, sdi_i, sclk_i}),
    .level_o (in_level),
    .rise_o  (in_rise)
  );

  assign shift_en  = in_rise[IdxSclk];
  assign load_rise = in_rise[IdxLoad];
  assign wr_en     = load_rise &  frame.wr;
  assign rd_load   = load_rise & ~frame.wr;

  cfg_frame_shifter u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (shift_en),
    .sdi_i     (in_level[IdxSdi]),
    .rd_load_i (rd_load),
    .rd_data_i (rd_data),
    .frame_o   (frame)
  );

  cfg_reg_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .addr_i    (frame.addr),
    .wr_data_i (frame.data),
    .rd_data_o (rd_data),
    .regs_o    (cfg_regs_o)
  );

  assign sdo_o = frame.wr;

  p_oob_read_frame_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load && ({1'b0, frame.addr} >= (CFG_ADDR_W+1)'(CFG_NUM_REGS)) |=> frame.data == '0);

  p_sdo_moves_on_shift_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en |=> $stable(sdo_o));
endmodule

// File: tb/cfg_chain_slave_test.sv
module cfg_chain_slave_test;
  localparam int NREG = 98;
  localparam int DW   = 10;

  logic clk = 1'b0, rst_ni = 1'b0, sclk = 1'b0, sdi = 1'b0, load = 1'b0;
  logic sdo;
  logic [NREG*DW-1:0] regs;

  always #2.5 clk = ~clk;

  cfg_chain_slave uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdi_i(sdi),
    .load_i(load), .sdo_o(sdo), .cfg_regs_o(regs)
  );

  typedef struct { logic b; string req; } item_t;
  item_t exp_q[$];

  int n_chk = 0, n_bad = 0;
  logic [17:0] m_frame;
  logic [DW-1:0] m_bank [NREG];
  string data_tag = "R3";

  task automatic check(input string req, input logic [NREG*DW-1:0] act, input logic [NREG*DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NREG*DW-1:0] model_vec();
    logic [NREG*DW-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*DW +: DW] = m_bank[i];
    return v;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  // driver: predicts the shifted-out bits, then shifts the new frame in (R2 layout)
  task automatic send_frame(input logic wr, input logic [6:0] addr, input logic [DW-1:0] data);
    logic [17:0] f;
    f = {wr, addr, data};
    for (int k = 0; k < 18; k++) begin
      item_t it;
      it.b   = m_frame[17-k];
      it.req = (k >= 8) ? data_tag : "R3";
      exp_q.push_back(it);
    end
    for (int k = 17; k >= 0; k--) begin
      @(negedge clk); sdi = f[k];
      wait_clk(4);
      @(negedge clk); sclk = 1'b1;
      wait_clk(4);
      @(negedge clk); sclk = 1'b0;
    end
    m_frame  = f;
    data_tag = "R3";
  endtask

  task automatic pulse_load();
    @(negedge clk); load = 1'b1;
    wait_clk(6);
    @(negedge clk); load = 1'b0;
    wait_clk(6);
    if (m_frame[17]) begin
      if (m_frame[16:10] < NREG) m_bank[m_frame[16:10]] = m_frame[9:0];
    end else begin
      if (m_frame[16:10] < NREG) begin
        m_frame[9:0] = m_bank[m_frame[16:10]];
        data_tag = "R5";
      end else begin
        m_frame[9:0] = '0;
        data_tag = "R7";
      end
    end
    @(negedge clk);
  endtask

  // monitor: compares sdo with the next predicted bit at every serial clock rise
  initial begin
    forever begin
      @(posedge sclk);
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        n_chk++;
        if (sdo !== it.b) begin
          n_bad++;
          $display("FAIL %s sdo actual=%b expected=%b", it.req, sdo, it.b);
        end
      end
    end
  end

  initial begin
    wait_clk(200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_frame = '0;
    for (int i = 0; i < NREG; i++) m_bank[i] = 10'h200;
    wait_clk(3);
    @(negedge clk);
    check("R1", regs, model_vec());
    check("R1", {{(NREG*DW-1){1'b0}}, sdo}, '0);
    rst_ni = 1'b1;
    wait_clk(3);
    @(negedge clk);
    check("R1", regs, model_vec());

    send_frame(1'b1, 7'd5, 10'h155);
    check("R8", regs, model_vec());
    pulse_load();
    check("R4", regs, model_vec());
    send_frame(1'b1, 7'd97, 10'h3ff); pulse_load(); check("R4", regs, model_vec());
    send_frame(1'b1, 7'd0,  10'h001); pulse_load(); check("R4", regs, model_vec());
    send_frame(1'b1, 7'd98, 10'h0aa); pulse_load(); check("R6", regs, model_vec());
    send_frame(1'b1, 7'd127,10'h2aa); pulse_load(); check("R6", regs, model_vec());
    send_frame(1'b0, 7'd5,  10'h000); pulse_load();
    send_frame(1'b0, 7'd100,10'h3c3); pulse_load();
    send_frame(1'b0, 7'd97, 10'h111); pulse_load();
    send_frame(1'b1, 7'd40, 10'h0f0);
    check("R8", regs, model_vec());
    send_frame(1'b0, 7'd0,  10'h222); pulse_load();
    send_frame(1'b1, 7'd1,  10'h333); pulse_load(); check("R4", regs, model_vec());
    send_frame(1'b0, 7'd1,  10'h000); pulse_load();
    send_frame(1'b0, 7'd2,  10'h000);
    check("R8", regs, model_vec());
    check("R3", {{(NREG*DW-1){1'b0}}, 1'(exp_q.size() != 0)}, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule